// File: doc/BRIEF.md
# Complementary PWM Generator with Dead Time

This block drives up to three half-bridge legs. One up/down carrier counter is shared by all legs. It climbs from 0 to a programmed period P and then descends back to 0, which gives a triangle carrier and center-aligned pulses. Each leg compares the carrier against its own compare value. The result sets the high-side gate and, inverted, the low-side gate. Every rising gate edge is held back by a programmable number of clocks, and falling edges pass through at once. This guarantees a fully-off gap between the two switches of a leg. Duty runs over the full range from 0% to 100% with a resolution of one clock.

A host programs the block through a simple write-only register port: the period, one compare value per leg, the dead count and an enable bit. The period and the compare values are copied into working registers only at the point where the carrier is about to return to 0. A write made mid-period therefore never tears a pulse.

The carrier is a three-state machine. CAR_IDLE holds the counter at 0 while the block is disabled; enabling moves it to CAR_RISE, or to CAR_FALL when P is 1. CAR_RISE counts up and turns to CAR_FALL when the next value reaches P. CAR_FALL counts down and turns to CAR_RISE when the next value is 0. Any state returns to CAR_IDLE when enable clears. Each gate has its own three-state machine. GT_OFF goes to GT_ON directly when its request rises and the dead count is 0; otherwise it goes to GT_WAIT. GT_WAIT counts the clocks the request has been held and moves to GT_ON once the count reaches the dead count. A dropped request sends it back to GT_OFF. GT_ON returns to GT_OFF the cycle after the request drops.

Top module: `cpwm_top`

## Requirements
- R1: While enabled, the carrier runs 0,1,…,P,P-1,…,1 and repeats, so one carrier cycle lasts 2P clocks. A programmed period of 0 behaves as P = 1.
- R2: A register write happens at a clock edge while wr_en is high. The address selects the register: 0 is the period, 1/2/3 are the compare values of legs 0/1/2, 4 is the dead count (low DW bits of wr_data), and 5 is the enable (bit 0).
- R3: The working period and compare values are reloaded only at the edge where the carrier's next value is 0, and at every edge while disabled. A compare write takes effect from the first carrier cycle that starts at least two clocks after the write edge.
- R4: The high-side request of a leg is active while the carrier is below its compare value. A compare of 0 never requests, and a compare at or above P requests for the whole carrier cycle.
- R5: While enabled, the low-side request of a leg is the inverse of its high-side request.
- R6: A gate falls one clock after its request drops. It rises one clock after its request has been held for D+1 consecutive clocks, where D is the dead count. Pulses shorter than that are suppressed.
- R7: The high-side and low-side gates of a leg are never active in the same cycle.
- R8: From the second cycle after the enable bit clears, all six gates are inactive (low), as they are in reset.
- R9: In the first cycle after enable is written to 1, the carrier is at 0, and the compare values written beforehand are in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CW | Write data |
| gate_hi | output | NCH | High-side gates, one bit per leg, active high |
| gate_lo | output | NCH | Low-side gates, one bit per leg, active high |

## Verification
The bench sweeps every compare value from 0 through P+1 on each leg, for small periods and several dead counts. This covers the 0% and 100% ends and the single-clock pulses at the carrier peak. A design that compared with the wrong inequality, or left out the saturation at compare ≥ P, would show a stray one-clock pulse or a one-clock gap at those ends. Dead counts longer than the pulse itself are included, so a gate machine that failed to suppress short pulses, or that delayed falling edges too, would miscompare. Compare writes land a few clocks before, and exactly at, the last clock that still reaches the next reload. A design that reloaded at the wrong edge would change the duty one carrier cycle early or late. Disabling mid-run and a programmed period of 0 catch gates left on and a carrier stuck at 0.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [1:0] {
        CAR_IDLE = 2'd0,
        CAR_RISE = 2'd1,
        CAR_FALL = 2'd2
    } car_state_e;

    typedef enum logic [1:0] {
        GT_OFF  = 2'd0,
        GT_WAIT = 2'd1,
        GT_ON   = 2'd2
    } gate_state_e;

    localparam logic [2:0] ADR_PERIOD = 3'd0;
    localparam logic [2:0] ADR_CMP0   = 3'd1;
    localparam logic [2:0] ADR_DEAD   = 3'd4;
    localparam logic [2:0] ADR_EN     = 3'd5;

endpackage

// File: rtl/cpwm_carrier.sv
module cpwm_carrier
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] prd_sh,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] prd,
    output logic          load
);

    localparam logic [CW-1:0] ONE = CW'(1);

    car_state_e    st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] prd_q;

    // next-state and next-count
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            CAR_IDLE: begin
                if (en) begin
                    cnt_n = ONE;
                    st_n  = (prd_q <= ONE) ? CAR_FALL : CAR_RISE;
                end else begin
                    cnt_n = '0;
                end
            end
            CAR_RISE: begin
                if (!en) begin
                    st_n  = CAR_IDLE;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + ONE;
                    st_n  = (cnt_n >= prd_q) ? CAR_FALL : CAR_RISE;
                end
            end
            CAR_FALL: begin
                if (!en) begin
                    st_n  = CAR_IDLE;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q - ONE;
                    st_n  = (cnt_q == ONE) ? CAR_RISE : CAR_FALL;
                end
            end
            default: begin
                st_n  = CAR_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CAR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // working period, reloaded when the carrier is about to hit zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prd_q <= ONE;
        else if (load)
            prd_q <= (prd_sh == '0) ? ONE : prd_sh;
    end

    // outputs
    always_comb begin
        load = (cnt_n == '0);
        cnt  = cnt_q;
        prd  = prd_q;
    end

endmodule

// File: rtl/cpwm_gate.sv
module cpwm_gate
    import cpwm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [DW-1:0] dead,
    output logic          act
);

    gate_state_e   st_q, st_n;
    logic [DW-1:0] wc_q, wc_n;

    always_comb begin
        st_n = st_q;
        wc_n = wc_q;
        unique case (st_q)
            GT_OFF: begin
                wc_n = '0;
                if (req) begin
                    if (dead == '0) begin
                        st_n = GT_ON;
                    end else begin
                        st_n = GT_WAIT;
                        wc_n = DW'(1);
                    end
                end
            end
            GT_WAIT: begin
                if (!req) begin
                    st_n = GT_OFF;
                    wc_n = '0;
                end else if (wc_q >= dead) begin
                    st_n = GT_ON;
                end else begin
                    wc_n = wc_q + DW'(1);
                end
            end
            GT_ON: begin
                if (!req) st_n = GT_OFF;
            end
            default: begin
                st_n = GT_OFF;
                wc_n = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= GT_OFF;
            wc_q <= '0;
        end else begin
            st_q <= st_n;
            wc_q <= wc_n;
        end
    end

    // output decode
    always_comb begin
        act = (st_q == GT_ON);
    end

endmodule

// File: rtl/cpwm_leg.sv
module cpwm_leg #(
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] prd,
    input  logic [CW-1:0] cmp_sh,
    input  logic [DW-1:0] dead,
    output logic          hi,
    output logic          lo
);

    logic [CW-1:0] cmp_q;
    logic          raw;
    logic          req_hi, req_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (load)
            cmp_q <= cmp_sh;
    end

    always_comb begin
        raw    = (cmp_q >= prd) || (cnt < cmp_q);
        req_hi = en && raw;
        req_lo = en && !raw;
    end

    cpwm_gate #(.DW(DW)) u_gate_hi (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req_hi),
        .dead (dead),
        .act  (hi)
    );

    cpwm_gate #(.DW(DW)) u_gate_lo (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req_lo),
        .dead (dead),
        .act  (lo)
    );

endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
    import cpwm_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DW  = 8,
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [NCH-1:0] gate_hi,
    output logic [NCH-1:0] gate_lo
);

    logic [CW-1:0] prd_sh;
    logic [CW-1:0] cmp_sh [NCH];
    logic [DW-1:0] dead_q;
    logic          en_q;

    logic [CW-1:0] car_cnt;
    logic [CW-1:0] car_prd;
    logic          car_load;

    // host register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_sh <= '0;
            dead_q <= '0;
            en_q   <= 1'b0;
            for (int k = 0; k < NCH; k++) cmp_sh[k] <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_PERIOD) prd_sh <= wr_data;
            if (wr_addr == ADR_DEAD)   dead_q <= wr_data[DW-1:0];
            if (wr_addr == ADR_EN)     en_q   <= wr_data[0];
            for (int k = 0; k < NCH; k++)
                if (wr_addr == ADR_CMP0 + 3'(k)) cmp_sh[k] <= wr_data;
        end
    end

    cpwm_carrier #(.CW(CW)) u_carrier (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .prd_sh(prd_sh),
        .cnt   (car_cnt),
        .prd   (car_prd),
        .load  (car_load)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_leg
        cpwm_leg #(.CW(CW), .DW(DW)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_q),
            .load  (car_load),
            .cnt   (car_cnt),
            .prd   (car_prd),
            .cmp_sh(cmp_sh[g]),
            .dead  (dead_q),
            .hi    (gate_hi[g]),
            .lo    (gate_lo[g])
        );
    end

endmodule

// File: rtl/cpwm_checks.sv
module cpwm_checks #(
    parameter int CW  = 16,
    parameter int DW  = 8,
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic [CW-1:0]  cnt,
    input logic [CW-1:0]  prd,
    input logic [DW-1:0]  dead,
    input logic [NCH-1:0] gate_hi,
    input logic [NCH-1:0] gate_lo
);

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= prd));

    assert_cnt_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |->
            (((cnt - $past(cnt)) == CW'(1)) || (($past(cnt) - cnt) == CW'(1))));

    assert_gates_off_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((gate_hi == '0) && (gate_lo == '0)));

    for (genvar g = 0; g < NCH; g++) begin : g_leg_chk
        assert_no_shoot_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hi[g] && gate_lo[g]));

        assert_hi_dead_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_hi[g]) && ($past(dead) != '0)) |-> !$past(gate_lo[g]));

        assert_lo_dead_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_lo[g]) && ($past(dead) != '0)) |-> !$past(gate_hi[g]));
    end

endmodule

bind cpwm_top cpwm_checks #(.CW(CW), .DW(DW), .NCH(NCH)) u_cpwm_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_q),
    .cnt    (car_cnt),
    .prd    (car_prd),
    .dead   (dead_q),
    .gate_hi(gate_hi),
    .gate_lo(gate_lo)
);

// File: tb/test_cpwm_top.sv
module test_cpwm_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  gate_hi;
    logic [2:0]  gate_lo;

    int vectors = 0;
    int errors  = 0;

    bit hreq [3][256];

    always #5 clk = ~clk;

    cpwm_top i_cpwm_top (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .gate_hi(gate_hi),
        .gate_lo(gate_lo)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // R2: one register write
    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int tri_at(int j, int p);
        int m = j % (2 * p);
        return (m <= p) ? m : 2 * p - m;
    endfunction

    task automatic run_case(input string tag, input int pcfg, input int d,
                            input int c0, input int c1, input int c2,
                            input int wcyc, input int wch, input int wval);
        int p = (pcfg == 0) ? 1 : pcfg;
        int cm [3];
        int total;
        int bound;
        logic [2:0] eh, el;
        cm[0] = c0; cm[1] = c1; cm[2] = c2;
        total = 6 * p + d + 2;
        bound = (wcyc < 0) ? total + 1 : ((wcyc + 2 + 2 * p - 1) / (2 * p)) * (2 * p);
        wr(3'd0, pcfg);
        wr(3'd1, c0);
        wr(3'd2, c1);
        wr(3'd3, c2);
        wr(3'd4, d);
        wr_en   = 1'b1;
        wr_addr = 3'd5;
        wr_data = 16'd1;
        for (int j = 0; j < total; j++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (j == bound) cm[wch] = wval;
            for (int ch = 0; ch < 3; ch++)
                hreq[ch][j] = (cm[ch] >= p) || (tri_at(j, p) < cm[ch]);
            for (int ch = 0; ch < 3; ch++) begin
                eh[ch] = 1'b1;
                el[ch] = 1'b1;
                for (int i = 0; i <= d; i++) begin
                    if (j - 1 - i < 0) begin
                        eh[ch] = 1'b0;
                        el[ch] = 1'b0;
                    end else begin
                        if (!hreq[ch][j - 1 - i]) eh[ch] = 1'b0;
                        if (hreq[ch][j - 1 - i])  el[ch] = 1'b0;
                    end
                end
            end
            check({tag, " R1 R2 R4 R6 R9 high side"}, gate_hi, eh);
            check({tag, " R5 R6 low side"}, gate_lo, el);
            check({tag, " R7 overlap"}, gate_hi & gate_lo, 3'b000);
            if (j == wcyc) begin
                wr_en   = 1'b1;
                wr_addr = 3'(wch + 1);
                wr_data = 16'(wval);
            end
        end
        wr_en   = 1'b1;
        wr_addr = 3'd5;
        wr_data = 16'd0;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check({tag, " R8 disabled high"}, gate_hi, 3'b000);
            check({tag, " R8 disabled low"}, gate_lo, 3'b000);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset high", gate_hi, 3'b000);
        check("R8 reset low", gate_lo, 3'b000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // duty sweep, R4 ends at compare 0 and compare >= P
        for (int p = 1; p <= 4; p++)
            for (int d = 0; d <= 2; d++)
                for (int c = 0; c <= p + 1; c++)
                    run_case("R4 sweep", p, d, c, (c + 1) % (p + 2), p + 1 - c, -1, 0, 0);

        // R3 compare reload at the carrier boundary
        run_case("R3 mid-period write", 4, 1, 1, 2, 3, 5, 0, 4);
        run_case("R3 last-chance write", 4, 0, 1, 2, 3, 6, 2, 0);
        run_case("R3 too-late write", 4, 2, 2, 2, 2, 7, 1, 5);

        // R1 period zero behaves as one
        run_case("R1 period zero", 0, 0, 1, 0, 2, -1, 0, 0);
        // R6 longer period and dead count
        run_case("R6 wide", 10, 4, 3, 7, 12, -1, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule